// File: doc/BRIEF.md
# Serial Data-Link Match-Character Receiver

This block is the receive front end of an unframed serial data link. A bit strobe marks each valid bit of the incoming serial stream. The block assembles the bits into octets, least significant bit first, and pushes each finished octet into a small receive queue. A system-side reader drains that queue.

The block has three capture modes:
- **Direct mode** stores every octet. The octet boundaries are counted from the first bit seen after the receiver is enabled.
- **Sliding hunt mode** compares a programmable match character against the last eight bits on every bit. When the character is found, it becomes the first stored octet and the octet framing restarts from that point.
- **Boundary hunt mode** makes the same comparison, but only at the octet boundaries counted from enable.

Status outputs report:
- whether capture has started and the bit offset at which the match completed;
- whether the queue fill has reached a programmable level;
- a sticky overrun flag.

An interrupt output combines the level and overrun conditions under a single enable. Setting the level to 1 turns the interrupt into a match notification in the hunt modes.

Top module: `dlink_hunt_rx`

## Requirements
- R1: With `match_en`=0, `match_found` goes to 1 after the first strobed bit following enable, with `match_offset`=000. Every 8 strobed bits from enable form one queue entry, and the first bit received lands in bit 0.
- R2: With `match_en`=1 and `bnd_only`=0, the last 8 bits (newest in bit 7) are compared with `match_char` on every bit once 8 bits have arrived. On a hit, `match_found`=1 and `match_offset` equals the hit bit's index since enable, modulo 8. Later octets are framed from the bit after the hit.
- R3: With `match_en`=1 and `bnd_only`=1, the comparison is made only on bits whose index since enable is 7 modulo 8. A hit there reports offset 111.
- R4: In both hunt modes, the queue receives nothing before the hit, and the matching character is the first entry written.
- R5: A hit that completes exactly on an octet boundary reports `match_offset`=111.
- R6: `level_hit` is 1 whenever `fifo_count` ≥ `fill_level`. `irq` = `irq_en` AND (`level_hit` OR `overrun`).
- R7: An octet that completes while the queue holds `DEPTH` entries is discarded, and `overrun` is set. `overrun` stays set until a cycle with `ovr_clr`=1.
- R8: While `rx_en`=0, the bit counters, the hunt state, `match_found` and `match_offset` are cleared. Entries already queued are kept.
- R9: The queue is first-in first-out. `rd_data` shows the oldest entry, and `rd_en` removes it when the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low clears framing and hunt state |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial data bit, sampled with `bit_stb` |
| match_en | input | 1 | 1 selects a hunt mode |
| bnd_only | input | 1 | In hunt mode, compare only at octet boundaries |
| match_char | input | 8 | Character to hunt for |
| fill_level | input | 7 | Queue fill threshold, 1 to 64 |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Remove the oldest queue entry |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| rd_data | output | 8 | Oldest queue entry |
| fifo_count | output | 7 | Number of queued entries |
| fifo_empty | output | 1 | Queue holds no entries |
| level_hit | output | 1 | Queue fill reached `fill_level` |
| overrun | output | 1 | Sticky octet-dropped flag |
| match_found | output | 1 | Capture has started (match seen, or first bit in direct mode) |
| match_offset | output | 3 | Bit offset of the hit within the original octet framing |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or alignment counter shows up at the ports within one octet time:
- a misplaced boundary shifts the bits of the next queued entry, so the value read back differs;
- in boundary hunt mode, a hit may be missed or accepted off-boundary, which shows as a queue count of zero or a wrong offset.

A hunt state that fails to clear on disable leaves `match_found` high in the cycle after enable drops. A wrong overrun or level path changes `irq` and `fifo_count` on the very octet that fills the queue.

// File: rtl/dlink_hunt_pkg.sv
package dlink_hunt_pkg;

    localparam int OCT_W = 8;
    localparam int POS_W = $clog2(OCT_W);

    typedef enum logic [1:0] {
        CAP_DIRECT = 2'd0,
        CAP_SLIDE  = 2'd1,
        CAP_BOUND  = 2'd2
    } cap_mode_e;

    typedef struct packed {
        logic             found;
        logic             primed;
        logic [POS_W-1:0] offset;
        logic [POS_W-1:0] bpos;
        logic [POS_W-1:0] apos;
    } hunt_state_t;

    function automatic cap_mode_e pick_mode(input logic hunt, input logic bound);
        if (!hunt)
            return CAP_DIRECT;
        else if (bound)
            return CAP_BOUND;
        else
            return CAP_SLIDE;
    endfunction

endpackage

// File: rtl/dlink_hunt_deser.sv
module dlink_hunt_deser
    import dlink_hunt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             bit_stb,
    input  logic             bit_in,
    input  logic             match_en,
    input  logic             bnd_only,
    input  logic [OCT_W-1:0] match_char,
    output logic             oct_wr,
    output logic [OCT_W-1:0] oct_data,
    output logic             found,
    output logic [POS_W-1:0] offset
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(OCT_W - 1);

    hunt_state_t      st_q, st_d;
    logic [OCT_W-1:0] shreg_q;
    logic [OCT_W-1:0] window;
    cap_mode_e        mode;
    logic             fire;
    logic             at_edge;
    logic             hit;

    always_comb begin
        mode    = pick_mode(match_en, bnd_only);
        fire    = rx_en & bit_stb;
        window  = {bit_in, shreg_q[OCT_W-1:1]};
        at_edge = (st_q.bpos == LAST_POS);
        case (mode)
            CAP_SLIDE: hit = (st_q.primed | at_edge) & (window == match_char);
            CAP_BOUND: hit = at_edge & (window == match_char);
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        oct_wr = 1'b0;
        if (fire) begin
            st_d.bpos   = st_q.bpos + 1'b1;
            st_d.primed = st_q.primed | at_edge;
            st_d.apos   = st_q.apos + 1'b1;
            if (st_q.found) begin
                oct_wr = (st_q.apos == LAST_POS);
            end else if (mode == CAP_DIRECT) begin
                st_d.found  = 1'b1;
                st_d.offset = '0;
            end else if (hit) begin
                oct_wr      = 1'b1;
                st_d.found  = 1'b1;
                st_d.offset = st_q.bpos;
                st_d.apos   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            st_q    <= '0;
            shreg_q <= '0;
        end else begin
            st_q <= st_d;
            if (fire)
                shreg_q <= window;
        end
    end

    assign oct_data = window;
    assign found    = st_q.found;
    assign offset   = st_q.offset;

endmodule

// File: rtl/dlink_hunt_fifo.sv
module dlink_hunt_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             dropped
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dropped = push & full;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wptr_q <= bump(wptr_q);
            if (do_pop)
                rptr_q <= bump(rptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/dlink_hunt_flags.sv
module dlink_hunt_flags #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dropped,
    input  logic             ovr_clr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] fill_level,
    input  logic             irq_en,
    output logic             level_hit,
    output logic             overrun,
    output logic             irq
);

    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= 1'b0;
        else if (dropped)
            ovr_q <= 1'b1;
        else if (ovr_clr)
            ovr_q <= 1'b0;
    end

    assign level_hit = (count >= fill_level);
    assign overrun   = ovr_q;
    assign irq       = irq_en & (level_hit | ovr_q);

endmodule

// File: rtl/dlink_hunt_rx.sv
module dlink_hunt_rx
    import dlink_hunt_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             bit_stb,
    input  logic             bit_in,
    input  logic             match_en,
    input  logic             bnd_only,
    input  logic [OCT_W-1:0] match_char,
    input  logic [CNT_W-1:0] fill_level,
    input  logic             irq_en,
    input  logic             rd_en,
    input  logic             ovr_clr,
    output logic [OCT_W-1:0] rd_data,
    output logic [CNT_W-1:0] fifo_count,
    output logic             fifo_empty,
    output logic             level_hit,
    output logic             overrun,
    output logic             match_found,
    output logic [POS_W-1:0] match_offset,
    output logic             irq
);

    logic             oct_wr;
    logic [OCT_W-1:0] oct_data;
    logic             q_full;
    logic             q_drop;

    dlink_hunt_deser u_deser (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .bit_stb    (bit_stb),
        .bit_in     (bit_in),
        .match_en   (match_en),
        .bnd_only   (bnd_only),
        .match_char (match_char),
        .oct_wr     (oct_wr),
        .oct_data   (oct_data),
        .found      (match_found),
        .offset     (match_offset)
    );

    dlink_hunt_fifo #(.WIDTH(OCT_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (oct_wr),
        .wdata   (oct_data),
        .pop     (rd_en),
        .rdata   (rd_data),
        .count   (fifo_count),
        .full    (q_full),
        .empty   (fifo_empty),
        .dropped (q_drop)
    );

    dlink_hunt_flags #(.CNT_W(CNT_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .dropped    (q_drop),
        .ovr_clr    (ovr_clr),
        .count      (fifo_count),
        .fill_level (fill_level),
        .irq_en     (irq_en),
        .level_hit  (level_hit),
        .overrun    (overrun),
        .irq        (irq)
    );

endmodule

// File: rtl/dlink_hunt_rx_chk.sv
module dlink_hunt_rx_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             match_en,
    input logic             bnd_only,
    input logic             rd_en,
    input logic             ovr_clr,
    input logic [CNT_W-1:0] fifo_count,
    input logic             overrun,
    input logic             match_found,
    input logic [2:0]       match_offset
);

    AST_NO_WRITE_BEFORE_HIT: assert property (@(posedge clk) disable iff (rst)
        (fifo_count > $past(fifo_count)) |-> match_found); // R4

    AST_BOUNDARY_OFFSET: assert property (@(posedge clk) disable iff (rst)
        ($rose(match_found) && match_en && bnd_only) |-> (match_offset == 3'd7)); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!match_found && match_offset == 3'd0)); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH)); // R7

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == CNT_W'(DEPTH) && !rd_en) |=> (fifo_count == CNT_W'(DEPTH))); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun); // R7

endmodule

bind dlink_hunt_rx dlink_hunt_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_en        (rx_en),
    .match_en     (match_en),
    .bnd_only     (bnd_only),
    .rd_en        (rd_en),
    .ovr_clr      (ovr_clr),
    .fifo_count   (fifo_count),
    .overrun      (overrun),
    .match_found  (match_found),
    .match_offset (match_offset)
);

// File: tb/dlink_hunt_rx_test.sv
module dlink_hunt_rx_test;

    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_en = 1'b0;
    logic             bit_stb = 1'b0;
    logic             bit_in = 1'b0;
    logic             match_en = 1'b0;
    logic             bnd_only = 1'b0;
    logic [7:0]       match_char = 8'h00;
    logic [CNT_W-1:0] fill_level = 7'd64;
    logic             irq_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             ovr_clr = 1'b0;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty;
    logic             level_hit;
    logic             overrun;
    logic             match_found;
    logic [2:0]       match_offset;
    logic             irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dlink_hunt_rx #(.DEPTH(DEPTH)) uut (
        .clk (clk), .rst (rst), .rx_en (rx_en), .bit_stb (bit_stb),
        .bit_in (bit_in), .match_en (match_en), .bnd_only (bnd_only),
        .match_char (match_char), .fill_level (fill_level), .irq_en (irq_en),
        .rd_en (rd_en), .ovr_clr (ovr_clr), .rd_data (rd_data),
        .fifo_count (fifo_count), .fifo_empty (fifo_empty),
        .level_hit (level_hit), .overrun (overrun), .match_found (match_found),
        .match_offset (match_offset), .irq (irq)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] expected);
        @(negedge clk);
        chk(tag, rd_data, expected);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_enable(input logic en);
        @(negedge clk);
        rx_en = en;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 reset count", fifo_count, 0);
        chk("R9 reset empty", fifo_empty, 1);
        chk("R1 reset found", match_found, 0);
        chk("R7 reset overrun", overrun, 0);
        chk("R6 reset irq", irq, 0);
    endtask

    task automatic t_direct;
        match_en = 1'b0;
        set_enable(1'b1);
        send_bit(1'b1);
        chk("R1 found after first bit", match_found, 1);
        chk("R1 offset zero", match_offset, 0);
        for (int i = 1; i < 8; i++) send_bit(i[0] ^ 1'b1);
        send_byte(8'hC3);
        chk("R1 two octets", fifo_count, 2);
        pop_chk("R1 first octet lsb first", 8'h55);
        pop_chk("R9 second octet", 8'hC3);
        set_enable(1'b0);
    endtask

    task automatic t_slide;
        match_en   = 1'b1;
        bnd_only   = 1'b0;
        match_char = 8'h7E;
        set_enable(1'b1);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        for (int i = 0; i < 7; i++) send_bit(8'h7E >> i);
        chk("R4 nothing before hit", fifo_count, 0);
        chk("R2 not found yet", match_found, 0);
        send_bit(1'b0);
        chk("R2 found", match_found, 1);
        chk("R2 offset", match_offset, 2);
        chk("R4 hit written", fifo_count, 1);
        send_byte(8'hA5);
        chk("R2 realigned count", fifo_count, 2);
        pop_chk("R4 hit first", 8'h7E);
        pop_chk("R2 realigned octet", 8'hA5);
        set_enable(1'b0);
        chk("R8 found cleared", match_found, 0);
        chk("R8 offset cleared", match_offset, 0);
    endtask

    task automatic t_aligned;
        match_en = 1'b1;
        bnd_only = 1'b0;
        set_enable(1'b1);
        send_byte(8'h7E);
        chk("R5 aligned offset", match_offset, 7);
        pop_chk("R5 aligned data", 8'h7E);
        set_enable(1'b0);
    endtask

    task automatic t_bound;
        match_en = 1'b1;
        bnd_only = 1'b1;
        set_enable(1'b1);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        send_byte(8'h7E);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        chk("R3 no off-boundary hit", fifo_count, 0);
        chk("R3 not found", match_found, 0);
        send_byte(8'h7E);
        chk("R3 found", match_found, 1);
        chk("R3 offset", match_offset, 7);
        pop_chk("R3 data", 8'h7E);
        set_enable(1'b0);
    endtask

    task automatic t_irq_match;
        match_en   = 1'b1;
        bnd_only   = 1'b0;
        match_char = 8'h3C;
        fill_level = 7'd1;
        irq_en     = 1'b1;
        set_enable(1'b1);
        send_byte(8'h00);
        chk("R6 irq quiet", irq, 0);
        send_byte(8'h3C);
        chk("R6 level hit", level_hit, 1);
        chk("R6 irq on match", irq, 1);
        chk("R5 offset", match_offset, 7);
        set_enable(1'b0);
        chk("R8 fifo kept", fifo_count, 1);
        pop_chk("R9 data", 8'h3C);
        chk("R6 irq low when empty", irq, 0);
    endtask

    task automatic t_overrun;
        match_en   = 1'b0;
        fill_level = 7'd64;
        irq_en     = 1'b1;
        set_enable(1'b1);
        for (int n = 0; n < 64; n++) send_byte(8'(n));
        chk("R7 full", fifo_count, 64);
        chk("R7 no overrun yet", overrun, 0);
        send_byte(8'hEE);
        chk("R7 count held", fifo_count, 64);
        chk("R7 overrun set", overrun, 1);
        send_byte(8'hEF);
        chk("R7 overrun sticky", overrun, 1);
        set_enable(1'b0);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R7 overrun cleared", overrun, 0);
        pop_chk("R7 oldest kept", 8'h00);
        chk("R6 level drop", level_hit, 0);
        chk("R6 irq drop", irq, 0);
        for (int n = 1; n < 64; n++) pop_chk("R9 order", 8'(n));
        chk("R9 empty", fifo_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_slide();
        t_aligned();
        t_bound();
        t_irq_match();
        t_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule